// File: doc/BRIEF.md
# Reuse-Aware Data-Capture Issue Window

This block is the instruction scheduler of a core that runs every instruction twice, once on a primary stream and once on a duplicate stream, and compares the two copies before commit. Each dispatched instruction takes two entries. Each entry holds its operand values as well as ready flags. A result broadcast of tag and value writes into every waiting operand with that tag. Only the primary stream broadcasts results, and those results wake operands in both primary and duplicate entries.

A duplicate entry can also hold two buffered operand values from an earlier execution, taken from a lookup in a reuse store outside this block. Once both of its operands are ready and each equals its buffered value, the duplicate does not use an ALU. It reports reuse completion with its destination tag, it broadcasts nothing, and its entry is released. Any other entry goes to an oldest-first select that issues up to `IW` entries per cycle. Primary entries always take this path. So do duplicates whose lookup missed or whose operands differ from the buffered values.

Top module: `reuse_issue_window`

## Requirements
- R1: Reset leaves every entry empty. `disp_ready` is then 1, `iss_valid` is all zero and `reuse_done` is 0.
- R2: A dispatch is accepted only while `disp_ready` is 1, which means at least two entries are free. An accepted dispatch fills one primary entry and one duplicate entry at the next clock edge. A dispatch offered while `disp_ready` is 0 is dropped and never issues.
- R3: An operand marked ready at dispatch stores the dispatched value. An operand that is not ready stores the broadcast value if a broadcast with the same tag arrives in the dispatch cycle. Otherwise it waits, and its entry cannot issue or complete by reuse.
- R4: A broadcast (`bc_valid`, `bc_tag`, `bc_val`) sets the value and the ready flag of every waiting operand whose tag equals `bc_tag`, in primary and duplicate entries alike. A broadcast with a different tag leaves the operand waiting.
- R5: A duplicate entry whose lookup hit (`disp_hit`=1) completes by reuse once both operands are ready and the left and right values equal `disp_buf_l` and `disp_buf_r`. It raises `reuse_done` with `reuse_dst` equal to its `disp_dst`, and it never appears on an issue slot. At most one reuse completion occurs per cycle, and the oldest eligible entry goes first.
- R6: A primary entry, or a duplicate whose lookup missed or whose operands differ from a buffered value, issues once both operands are ready. It carries its captured values on `iss_l` and `iss_r`, its tag on `iss_dst`, and `iss_dup` set to 1 only for a duplicate. An entry becomes eligible in the cycle after its last operand is captured.
- R7: Each cycle, up to `IW` eligible entries are issued in age order, with slot 0 the oldest. For one instruction the primary entry counts as older than its duplicate. Slot k is valid only if slot k-1 is valid.
- R8: An entry that issues or completes by reuse is freed at that clock edge and does not show up again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | At least two entries free |
| disp_dst | input | TW | Destination tag of the instruction |
| disp_l_rdy | input | 1 | Left operand value present at dispatch |
| disp_l_tag | input | TW | Producer tag of left operand |
| disp_l_val | input | DW | Left operand value when ready |
| disp_r_rdy | input | 1 | Right operand value present at dispatch |
| disp_r_tag | input | TW | Producer tag of right operand |
| disp_r_val | input | DW | Right operand value when ready |
| disp_hit | input | 1 | Reuse lookup hit for the duplicate |
| disp_buf_l | input | DW | Buffered left operand value |
| disp_buf_r | input | DW | Buffered right operand value |
| bc_valid | input | 1 | Primary-stream result broadcast |
| bc_tag | input | TW | Broadcast tag |
| bc_val | input | DW | Broadcast value |
| iss_valid | output | IW | Issue slot valid, slot 0 oldest |
| iss_dst | output | IW*TW | Destination tag per slot |
| iss_dup | output | IW | Slot holds a duplicate |
| iss_l | output | IW*DW | Left operand value per slot |
| iss_r | output | IW*DW | Right operand value per slot |
| reuse_done | output | 1 | A duplicate completed by reuse |
| reuse_dst | output | TW | Destination tag of that duplicate |

## Verification
The assertions assume at most one broadcast per cycle. They also assume that a tag is not broadcast again while an earlier consumer of it still waits, and that reset is applied for at least one edge before use. The stimulus gives every live producer tag a unique value and drives one broadcast at a time. It only re-uses a tag after every entry that waited on it has left the window. Sweeps cover hit against miss, with the left and right buffered values each matching or not. They also vary when the operand is delivered: at dispatch, in the dispatch cycle, or later after a broadcast with the wrong tag.

// File: rtl/reuse_issue_window.sv
module reuse_issue_window #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  parameter int TW    = 4,
  parameter int IW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disp_valid,
  output logic             disp_ready,
  input  logic [TW-1:0]    disp_dst,
  input  logic             disp_l_rdy,
  input  logic [TW-1:0]    disp_l_tag,
  input  logic [DW-1:0]    disp_l_val,
  input  logic             disp_r_rdy,
  input  logic [TW-1:0]    disp_r_tag,
  input  logic [DW-1:0]    disp_r_val,
  input  logic             disp_hit,
  input  logic [DW-1:0]    disp_buf_l,
  input  logic [DW-1:0]    disp_buf_r,
  input  logic             bc_valid,
  input  logic [TW-1:0]    bc_tag,
  input  logic [DW-1:0]    bc_val,
  output logic [IW-1:0]    iss_valid,
  output logic [IW*TW-1:0] iss_dst,
  output logic [IW-1:0]    iss_dup,
  output logic [IW*DW-1:0] iss_l,
  output logic [IW*DW-1:0] iss_r,
  output logic             reuse_done,
  output logic [TW-1:0]    reuse_dst
);
  localparam int IXW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] valid_q, dup_q, rv_q, rdyl_q, rdyr_q;
  logic [TW-1:0]    tagl_q [DEPTH];
  logic [TW-1:0]    tagr_q [DEPTH];
  logic [TW-1:0]    dst_q  [DEPTH];
  logic [DW-1:0]    vall_q [DEPTH];
  logic [DW-1:0]    valr_q [DEPTH];
  logic [DW-1:0]    bufl_q [DEPTH];
  logic [DW-1:0]    bufr_q [DEPTH];
  logic [DEPTH-1:0] age_q  [DEPTH];   // age_q[i][j]: entry j is older than i

  logic [DEPTH-1:0] mism, rdy2l, rdy2r, req, rreq, rpick, issued, done_mask, alloc_mask;
  logic [DEPTH-1:0] pick [IW];
  logic [DEPTH-1:0] taken;
  logic [IXW-1:0]   ip, id;
  logic             alloc;
  int               nfree;

  // Two comparators per entry; a cleared reuse-valid bit forces a mismatch
  always_comb
    for (int i = 0; i < DEPTH; i++) begin
      mism[i]  = !rv_q[i] || (vall_q[i] != bufl_q[i]) || (valr_q[i] != bufr_q[i]);
      rdy2l[i] = mism[i] & rdyl_q[i];
      rdy2r[i] = mism[i] & rdyr_q[i];
    end

  assign req  = valid_q & rdy2l & rdy2r;
  assign rreq = valid_q & dup_q & rdyl_q & rdyr_q & ~mism;

  always_comb begin
    nfree = 0; ip = '0; id = '0;
    for (int i = 0; i < DEPTH; i++)
      if (!valid_q[i]) begin
        if (nfree == 0) ip = i[IXW-1:0];
        else if (nfree == 1) id = i[IXW-1:0];
        nfree = nfree + 1;
      end
  end
  assign disp_ready = (nfree >= 2);
  assign alloc      = disp_valid && disp_ready;
  always_comb begin
    alloc_mask = '0;
    if (alloc) begin
      alloc_mask[ip] = 1'b1;
      alloc_mask[id] = 1'b1;
    end
  end

  // Oldest-first select, one slot after another
  always_comb begin
    taken = '0;
    for (int k = 0; k < IW; k++) begin
      pick[k] = '0;
      for (int i = 0; i < DEPTH; i++)
        if (req[i] && !taken[i] && ((age_q[i] & req & ~taken) == '0)) pick[k][i] = 1'b1;
      taken = taken | pick[k];
    end
    issued = taken;
    rpick = '0;
    for (int i = 0; i < DEPTH; i++)
      if (rreq[i] && ((age_q[i] & rreq) == '0)) rpick[i] = 1'b1;
  end
  assign done_mask = issued | rpick;

  always_comb begin
    iss_valid = '0; iss_dup = '0; iss_dst = '0; iss_l = '0; iss_r = '0;
    reuse_done = |rpick; reuse_dst = '0;
    for (int k = 0; k < IW; k++)
      for (int i = 0; i < DEPTH; i++)
        if (pick[k][i]) begin
          iss_valid[k]         = 1'b1;
          iss_dup[k]           = dup_q[i];
          iss_dst[k*TW +: TW]  = dst_q[i];
          iss_l[k*DW +: DW]    = vall_q[i];
          iss_r[k*DW +: DW]    = valr_q[i];
        end
    for (int i = 0; i < DEPTH; i++)
      if (rpick[i]) reuse_dst = dst_q[i];
  end

  wire          l_cap  = disp_l_rdy || (bc_valid && bc_tag == disp_l_tag);
  wire          r_cap  = disp_r_rdy || (bc_valid && bc_tag == disp_r_tag);
  wire [DW-1:0] l_val0 = disp_l_rdy ? disp_l_val : bc_val;
  wire [DW-1:0] r_val0 = disp_r_rdy ? disp_r_val : bc_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      valid_q <= (valid_q & ~done_mask) | alloc_mask;
      for (int i = 0; i < DEPTH; i++)
        if (valid_q[i] && bc_valid) begin
          if (!rdyl_q[i] && tagl_q[i] == bc_tag) begin rdyl_q[i] <= 1'b1; vall_q[i] <= bc_val; end
          if (!rdyr_q[i] && tagr_q[i] == bc_tag) begin rdyr_q[i] <= 1'b1; valr_q[i] <= bc_val; end
        end
      if (alloc) begin
        for (int j = 0; j < DEPTH; j++) begin
          age_q[j][ip] <= 1'b0;
          age_q[j][id] <= 1'b0;
        end
        age_q[ip] <= valid_q;
        age_q[id] <= valid_q | (DEPTH'(1) << ip);
        dup_q[ip] <= 1'b0;       rv_q[ip] <= 1'b0;
        dup_q[id] <= 1'b1;       rv_q[id] <= disp_hit;
        bufl_q[ip] <= '0;        bufr_q[ip] <= '0;
        bufl_q[id] <= disp_buf_l; bufr_q[id] <= disp_buf_r;
        dst_q[ip]  <= disp_dst;   dst_q[id]  <= disp_dst;
        tagl_q[ip] <= disp_l_tag; tagl_q[id] <= disp_l_tag;
        tagr_q[ip] <= disp_r_tag; tagr_q[id] <= disp_r_tag;
        rdyl_q[ip] <= l_cap;      rdyl_q[id] <= l_cap;
        rdyr_q[ip] <= r_cap;      rdyr_q[id] <= r_cap;
        vall_q[ip] <= l_val0;     vall_q[id] <= l_val0;
        valr_q[ip] <= r_val0;     valr_q[id] <= r_val0;
      end
    end
  end

  assert_drop_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_ready) |=> ($countones(valid_q) <= $past($countones(valid_q))));
  assert_reuse_dup_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reuse_done |-> (((rpick & ~dup_q) == '0) && ((rpick & issued) == '0)));
  assert_slot_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid[IW-1] |-> iss_valid[0]);
  assert_freed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|done_mask) |=> ((valid_q & $past(done_mask)) == '0));
  assert_issue_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid[0] |-> $countones(issued & ~(rdyl_q & rdyr_q & valid_q)) == 0);
endmodule

// File: tb/tb_reuse_issue_window.sv
module tb_reuse_issue_window;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic disp_valid, disp_l_rdy, disp_r_rdy, disp_hit, bc_valid;
  logic [3:0] disp_dst, disp_l_tag, disp_r_tag, bc_tag;
  logic [7:0] disp_l_val, disp_r_val, disp_buf_l, disp_buf_r, bc_val;
  logic disp_ready, reuse_done;
  logic [1:0] iss_valid, iss_dup;
  logic [7:0] iss_dst;
  logic [15:0] iss_l, iss_r;
  logic [3:0] reuse_dst;

  reuse_issue_window dut (.*);

  int vectors = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    disp_valid = 0; disp_dst = 0; disp_l_rdy = 0; disp_l_tag = 0; disp_l_val = 0;
    disp_r_rdy = 0; disp_r_tag = 0; disp_r_val = 0; disp_hit = 0;
    disp_buf_l = 0; disp_buf_r = 0; bc_valid = 0; bc_tag = 0; bc_val = 0;
  endtask

  task automatic disp(input logic [3:0] dst, input logic lr, input logic [3:0] lt, input logic [7:0] lv,
                      input logic [7:0] rv, input logic hit, input logic [7:0] bl, input logic [7:0] br);
    disp_valid = 1; disp_dst = dst; disp_l_rdy = lr; disp_l_tag = lt; disp_l_val = lv;
    disp_r_rdy = 1; disp_r_tag = 0; disp_r_val = rv; disp_hit = hit; disp_buf_l = bl; disp_buf_r = br;
  endtask

  task automatic empty_chk(input string req);
    chk(req, "iss_valid empty", int'(iss_valid), 0);
    chk(req, "reuse_done idle", int'(reuse_done), 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "disp_ready", int'(disp_ready), 1);
    empty_chk("R1");

    // Sweep: hit/miss x left match x right match x values (R5, R6, R7, R8)
    for (int h = 0; h < 2; h++)
      for (int ml = 0; ml < 2; ml++)
        for (int mr = 0; mr < 2; mr++)
          for (int v = 0; v < 3; v++) begin
            logic [7:0] lv, rv;
            logic [3:0] d;
            bit er;
            lv = 8'(16 + v * 7); rv = 8'(8'h33 ^ v); d = 4'(h * 8 + ml * 4 + mr * 2 + v);
            er = (h == 1) && (ml == 1) && (mr == 1);
            disp(d, 1, 0, lv, rv, 1'(h), ml ? lv : lv ^ 8'h01, mr ? rv : rv ^ 8'h80);
            @(negedge clk); idle();
            chk("R6", "slot0 valid", int'(iss_valid[0]), 1);
            chk("R7", "slot0 primary", int'(iss_dup[0]), 0);
            chk("R6", "slot0 dst", int'(iss_dst[3:0]), int'(d));
            chk("R6", "slot0 left", int'(iss_l[7:0]), int'(lv));
            chk("R6", "slot0 right", int'(iss_r[7:0]), int'(rv));
            chk("R5", "reuse_done", int'(reuse_done), int'(er));
            if (er) begin
              chk("R5", "reuse_dst", int'(reuse_dst), int'(d));
              chk("R5", "dup not issued", int'(iss_valid[1]), 0);
            end else begin
              chk("R6", "slot1 valid", int'(iss_valid[1]), 1);
              chk("R7", "slot1 dup", int'(iss_dup[1]), 1);
              chk("R6", "slot1 left", int'(iss_l[15:8]), int'(lv));
              chk("R6", "slot1 right", int'(iss_r[15:8]), int'(rv));
            end
            @(negedge clk);
            empty_chk("R8");
          end

    // Operand delivery timing: later, in dispatch cycle, after a wrong tag (R3, R4)
    for (int m = 0; m < 3; m++)
      for (int v = 0; v < 4; v++) begin
        logic [7:0] bv;
        logic [3:0] t;
        bit er;
        t = 4'(v + 1); bv = 8'(8'h40 + v * 9); er = (v % 2) == 1;
        disp(4'(v + 5), 0, t, 8'hEE, 8'h05, 1, er ? bv : bv + 8'd1, 8'h05);
        if (m == 1) begin bc_valid = 1; bc_tag = t; bc_val = bv; end
        @(negedge clk); idle();
        if (m != 1) begin
          empty_chk("R3");
          if (m == 2) begin
            bc_valid = 1; bc_tag = t + 4'd8; bc_val = ~bv;
            @(negedge clk); idle();
            empty_chk("R4");
          end
          bc_valid = 1; bc_tag = t; bc_val = bv;
          @(negedge clk); idle();
        end
        chk("R4", "primary woken", int'(iss_valid[0]), 1);
        chk("R3", "captured left", int'(iss_l[7:0]), int'(bv));
        chk("R5", "reuse after wake", int'(reuse_done), int'(er));
        chk("R4", "duplicate woken", int'(iss_valid[1]), int'(!er));
        if (!er) chk("R4", "dup left", int'(iss_l[15:8]), int'(bv));
        @(negedge clk);
        empty_chk("R8");
      end

    // Fill the window, offer a dropped dispatch, then drain in age order (R2, R7)
    for (int k = 0; k < 4; k++) begin
      disp(4'(k), 0, 15, 0, 8'(k), 0, 0, 0);
      @(negedge clk); idle();
    end
    chk("R2", "disp_ready when full", int'(disp_ready), 0);
    empty_chk("R2");
    disp(4'd9, 1, 0, 8'h11, 8'h22, 0, 0, 0);
    bc_valid = 1; bc_tag = 15; bc_val = 8'h77;
    @(negedge clk); idle();
    for (int c = 0; c < 4; c++) begin
      chk("R7", "both slots", int'(iss_valid), 3);
      chk("R7", "slot0 dst", int'(iss_dst[3:0]), c);
      chk("R7", "slot0 primary", int'(iss_dup[0]), 0);
      chk("R7", "slot1 dst", int'(iss_dst[7:4]), c);
      chk("R7", "slot1 dup", int'(iss_dup[1]), 1);
      chk("R4", "fill left", int'(iss_l[7:0]), 8'h77);
      chk("R6", "fill right", int'(iss_r[15:8]), c);
      @(negedge clk);
    end
    empty_chk("R2");
    chk("R2", "disp_ready after drain", int'(disp_ready), 1);

    // Two reuse completions ready together: one per cycle, oldest first (R5)
    disp(4'd1, 0, 3, 0, 8'h0A, 1, 8'h21, 8'h0A);
    @(negedge clk); idle();
    disp(4'd2, 0, 3, 0, 8'h0A, 1, 8'h21, 8'h0A);
    @(negedge clk); idle();
    bc_valid = 1; bc_tag = 3; bc_val = 8'h21;
    @(negedge clk); idle();
    chk("R7", "primaries issued", int'(iss_valid), 3);
    chk("R7", "older primary slot0", int'(iss_dst[3:0]), 1);
    chk("R7", "younger primary slot1", int'(iss_dst[7:4]), 2);
    chk("R5", "first reuse", int'(reuse_done), 1);
    chk("R5", "oldest reuse dst", int'(reuse_dst), 1);
    @(negedge clk);
    chk("R5", "second reuse", int'(reuse_done), 1);
    chk("R5", "second reuse dst", int'(reuse_dst), 2);
    chk("R8", "no issue", int'(iss_valid), 0);
    @(negedge clk);
    empty_chk("R8");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule